// File: doc/BRIEF.md
# Single-Wire Gauge Bus Master

This block drives a single-wire, half-duplex serial bus of the kind used to talk to battery fuel gauges. Software reaches it through byte-wide registers on a simple synchronous read/write port. The block performs one operation per request. It can send a long initialization (break) pulse, shift a byte out to the slave, or shift a byte in from the slave. When an operation ends, it raises a status flag and, if enabled, an interrupt.

The wire side is open drain. The block only ever requests a low level through `line_drive_lo_o`, and the pad's pull-up returns the line high. The line level comes back on `line_i` and passes through a two-flop synchronizer. Bit-cell timing is set by parameters counted in core clock cycles.

A request is made by writing the control register with the GO bit set. INIT and DIR in the same write choose the operation. GO clears itself when the operation ends, and the interrupt status register clears itself when it is read.

Top module: `sgm_top`

## Requirements
- R1: After reset, the revision register reads {REV_MAJOR, REV_MINOR}. Control (0x0C) and interrupt status (0x10) read 0x00, system status (0x18) reads 0x01, `line_drive_lo_o` is 0 and `irq_o` is 0.
- R2: The revision register at 0x00 holds the major version in bits 7:4 and the minor version in bits 3:0.
- R3: Writing control with GO (bit 4) and INIT (bit 2) set drives the line low for exactly BREAK_LO cycles, then releases it for BREAK_REC cycles. At the end, the timeout flag (interrupt status bit 0) is set and control bits 4 and 2 both read 0.
- R4: Writing control with GO set and INIT and DIR (bit 1) clear sends the byte in transmit data (0x04) least-significant bit first. Each bit starts a low pulse every CELL cycles: ONE_LO cycles long for a 1 and ZERO_LO cycles long for a 0. At the end, transmit complete (interrupt status bit 2) is set and GO clears.
- R5: Writing control with GO and DIR set receives a byte least-significant bit first. Each bit is sampled SAMPLE cycles after a detected falling edge: a high line gives 1 and a low line gives 0. The byte appears in receive data (0x08), receive complete (interrupt status bit 1) is set and GO clears.
- R6: During a receive, if no falling edge is seen within RX_WAIT cycles, the operation ends with the timeout flag instead of receive complete, and receive data keeps its old value.
- R7: A read of interrupt status returns the pending flags and clears them, so the next read returns 0x00.
- R8: `irq_o` is high exactly when the interrupt-enable bit (control bit 6) is set and at least one status flag is pending.
- R9: While GO reads 1, writes to the control register are ignored.
- R10: Bit 0 of system config (0x14) is a writable auto-idle bit. Writing 1 to bit 1 starts a soft reset. Reset done (system status bit 0) then reads 0 for RST_CYCLES cycles, after which it reads 1 and control, transmit data, system config and status all read their reset values.
- R11: The master never drives the line while idle or while receiving. `line_drive_lo_o` is the only line output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| line_i | input | 1 | Line level from the pad (asynchronous) |
| line_drive_lo_o | output | 1 | Pulls the line low when 1 |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Read data is combinational, so the bench samples `bus_rdata_o` in the same cycle that it presents the address. A clear-on-read takes effect at the closing edge of that cycle. A finished operation clears GO and sets its flag on the same clock edge, so the bench polls control until GO reads 0 and only then reads the flags or checks `irq_o`. Line pulses are measured in whole clock cycles at the falling clock edge, which means widths and cell spacing are compared exactly against the parameters. On receive, the bench model of the slave places its edges so that the sample point lands well inside the short or long low phase, which allows for the two-cycle synchronizer delay.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_REV   = 5'h00;
  localparam logic [ADDR_W-1:0] A_TXD   = 5'h04;
  localparam logic [ADDR_W-1:0] A_RXD   = 5'h08;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_ISR   = 5'h10;
  localparam logic [ADDR_W-1:0] A_SCFG  = 5'h14;
  localparam logic [ADDR_W-1:0] A_SSTAT = 5'h18;

  // control bit positions
  localparam int C_IE = 6, C_CLKEN = 5, C_GO = 4, C_INIT = 2, C_DIR = 1, C_MODE = 0;

  typedef enum logic [1:0] {OP_BREAK, OP_TX, OP_RX} op_e;

  // field order matches status bits 2..0
  typedef struct packed {
    logic tx;
    logic rx;
    logic to;
  } done_t;
endpackage

// File: rtl/sgm_sync.sv
module sgm_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sgm_phy.sv
module sgm_phy
  import sgm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BREAK_LO  = 9500,
  parameter int BREAK_REC = 2000,
  parameter int CELL      = 9500,
  parameter int ONE_LO    = 1600,
  parameter int ZERO_LO   = 5000,
  parameter int SAMPLE    = 3000,
  parameter int RX_WAIT   = 15000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              line_i,
  output logic              drive_lo_o,
  output done_t             done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_CYC = max2(max2(max2(BREAK_LO, BREAK_REC), max2(CELL, RX_WAIT)),
                                max2(SAMPLE, ZERO_LO));
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int BIT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_BRK_LO, S_BRK_REC, S_TX_LO, S_TX_HI, S_RX_WAIT, S_RX_SAMP} st_e;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic              drive_q, prev_q;
  done_t             done_q;

  logic [CNT_W-1:0] low_end;
  logic             fall, last_bit;

  assign low_end  = sh_q[0] ? CNT_W'(ONE_LO - 1) : CNT_W'(ZERO_LO - 1);
  assign fall     = prev_q & ~line_i;
  assign last_bit = (bit_q == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
      drive_q <= 1'b0; prev_q <= 1'b1; done_q <= '0;
    end else if (clr_i) begin
      st_q <= S_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
      drive_q <= 1'b0; prev_q <= 1'b1; done_q <= '0;
    end else begin
      done_q <= '0;
      prev_q <= line_i;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          cnt_q <= '0;
          bit_q <= '0;
          unique case (op_i)
            OP_BREAK: begin st_q <= S_BRK_LO; drive_q <= 1'b1; end
            OP_TX:    begin st_q <= S_TX_LO;  drive_q <= 1'b1; sh_q <= tx_byte_i; end
            default:  st_q <= S_RX_WAIT;
          endcase
        end
        S_BRK_LO: begin
          if (cnt_q == CNT_W'(BREAK_LO - 1)) begin
            drive_q <= 1'b0; cnt_q <= '0; st_q <= S_BRK_REC;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_BRK_REC: begin
          if (cnt_q == CNT_W'(BREAK_REC - 1)) begin
            done_q.to <= 1'b1; st_q <= S_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_TX_LO: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == low_end) begin drive_q <= 1'b0; st_q <= S_TX_HI; end
        end
        S_TX_HI: begin
          if (cnt_q == CNT_W'(CELL - 1)) begin
            if (last_bit) begin
              done_q.tx <= 1'b1; st_q <= S_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1; sh_q <= sh_q >> 1;
              cnt_q <= '0; drive_q <= 1'b1; st_q <= S_TX_LO;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_RX_WAIT: begin
          if (fall) begin
            cnt_q <= '0; st_q <= S_RX_SAMP;
          end else if (cnt_q == CNT_W'(RX_WAIT - 1)) begin
            done_q.to <= 1'b1; st_q <= S_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_RX_SAMP: begin
          if (cnt_q == CNT_W'(SAMPLE - 1)) begin
            sh_q  <= {line_i, sh_q[DATA_W-1:1]};
            cnt_q <= '0;
            if (last_bit) begin
              rx_q <= {line_i, sh_q[DATA_W-1:1]};
              done_q.rx <= 1'b1; st_q <= S_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1; st_q <= S_RX_WAIT;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign drive_lo_o = drive_q;
  assign done_o     = done_q;
  assign rx_byte_o  = rx_q;

  a_r11_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE || st_q == S_RX_WAIT || st_q == S_RX_SAMP) |-> !drive_q);
  a_r4_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_q) |-> $onehot(done_q));
  a_r4_low_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_TX_LO) |-> (cnt_q < CNT_W'(max2(ONE_LO, ZERO_LO))));
  a_r6_wait_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RX_WAIT) |-> (cnt_q < CNT_W'(RX_WAIT)));
endmodule

// File: rtl/sgm_top.sv
module sgm_top
  import sgm_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          BREAK_LO   = 9500,
  parameter int          BREAK_REC  = 2000,
  parameter int          CELL       = 9500,
  parameter int          ONE_LO     = 1600,
  parameter int          ZERO_LO    = 5000,
  parameter int          SAMPLE     = 3000,
  parameter int          RX_WAIT    = 15000,
  parameter int          RST_CYCLES = 16,
  parameter logic [3:0]  REV_MAJOR  = 4'h1,
  parameter logic [3:0]  REV_MINOR  = 4'h3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              line_i,
  output logic              line_drive_lo_o,
  output logic              irq_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic ie_q, clken_q, go_q, init_q, dir_q, mode_q, aidle_q;
  logic srst_busy_q, sys_done_q;
  logic [RC_W-1:0]   rcnt_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  done_t             flags_q;

  logic  line_s, wr, rd_isr, wr_ctrl, srst_req, start, any_done;
  op_e   op;
  done_t phy_done;
  logic [DATA_W-1:0] phy_rx;

  assign wr       = bus_sel_i & bus_we_i & ~srst_busy_q;
  assign rd_isr   = bus_sel_i & ~bus_we_i & (bus_addr_i == A_ISR);
  assign wr_ctrl  = wr & (bus_addr_i == A_CTRL);
  assign srst_req = wr & (bus_addr_i == A_SCFG) & bus_wdata_i[1];
  assign start    = wr_ctrl & ~go_q & bus_wdata_i[C_GO];
  assign op       = bus_wdata_i[C_INIT] ? OP_BREAK : (bus_wdata_i[C_DIR] ? OP_RX : OP_TX);
  assign any_done = |phy_done;

  sgm_sync #(.STAGES(2), .RST_VAL(1'b1)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  sgm_phy #(
    .DATA_W(DATA_W), .BREAK_LO(BREAK_LO), .BREAK_REC(BREAK_REC), .CELL(CELL),
    .ONE_LO(ONE_LO), .ZERO_LO(ZERO_LO), .SAMPLE(SAMPLE), .RX_WAIT(RX_WAIT)
  ) i_phy (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(srst_busy_q), .start_i(start), .op_i(op),
    .tx_byte_i(txd_q), .line_i(line_s), .drive_lo_o(line_drive_lo_o),
    .done_o(phy_done), .rx_byte_o(phy_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ie_q, clken_q, go_q, init_q, dir_q, mode_q, aidle_q} <= '0;
      txd_q <= '0; rxd_q <= '0; flags_q <= '0;
      srst_busy_q <= 1'b0; sys_done_q <= 1'b1; rcnt_q <= '0;
    end else if (srst_busy_q || srst_req) begin
      {ie_q, clken_q, go_q, init_q, dir_q, mode_q, aidle_q} <= '0;
      txd_q <= '0; rxd_q <= '0; flags_q <= '0;
      if (srst_req) begin
        srst_busy_q <= 1'b1; sys_done_q <= 1'b0; rcnt_q <= '0;
      end else if (rcnt_q == RC_W'(RST_CYCLES - 1)) begin
        srst_busy_q <= 1'b0; sys_done_q <= 1'b1;
      end else rcnt_q <= rcnt_q + 1'b1;
    end else begin
      if (wr_ctrl && !go_q) begin
        ie_q    <= bus_wdata_i[C_IE];
        clken_q <= bus_wdata_i[C_CLKEN];
        go_q    <= bus_wdata_i[C_GO];
        init_q  <= bus_wdata_i[C_INIT];
        dir_q   <= bus_wdata_i[C_DIR];
        mode_q  <= bus_wdata_i[C_MODE];
      end
      if (any_done) begin
        go_q   <= 1'b0;
        init_q <= 1'b0;
      end
      flags_q <= (rd_isr ? done_t'('0) : flags_q) | phy_done;
      if (phy_done.rx) rxd_q <= phy_rx;
      if (wr && bus_addr_i == A_TXD)  txd_q   <= bus_wdata_i[DATA_W-1:0];
      if (wr && bus_addr_i == A_SCFG) aidle_q <= bus_wdata_i[0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_REV:   bus_rdata_o = {REV_MAJOR, REV_MINOR};
      A_TXD:   bus_rdata_o = REG_W'(txd_q);
      A_RXD:   bus_rdata_o = REG_W'(rxd_q);
      A_CTRL:  bus_rdata_o = {1'b0, ie_q, clken_q, go_q, 1'b0, init_q, dir_q, mode_q};
      A_ISR:   bus_rdata_o = {5'b0, flags_q};
      A_SCFG:  bus_rdata_o = {6'b0, srst_busy_q, aidle_q};
      A_SSTAT: bus_rdata_o = {7'b0, sys_done_q};
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = ie_q & (|flags_q);

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_isr && !any_done) |=> (flags_q == '0));
  a_r3_break_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_done && init_q && !srst_busy_q && !srst_req) |=> (!go_q && !init_q && flags_q.to));
  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && !any_done && !srst_req && !srst_busy_q) |=>
      (go_q && $stable(init_q) && $stable(dir_q) && $stable(ie_q)));
  a_r5_rx_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_done.rx && !srst_busy_q && !srst_req) |=> (rxd_q == $past(phy_rx)));
  a_r10_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_done_q) |-> (!go_q && !ie_q && txd_q == '0 && flags_q == '0 && !aidle_q));
endmodule

// File: tb/test_sgm_top.sv
module test_sgm_top;
  localparam int BREAK_LO = 40, BREAK_REC = 10, CELL = 40, ONE_LO = 7, ZERO_LO = 20;
  localparam int SAMPLE = 14, RX_WAIT = 60, RST_CYCLES = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [4:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0, bus_rdata_o;
  logic line_drive_lo_o, irq_o, slave_lo = 1'b0, line_i;

  int checks = 0, errors = 0, cyc = 0, mon_n = 0;
  int mon_st[16], mon_w[16];
  logic mon_prev = 1'b0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;
  assign line_i = ~(line_drive_lo_o | slave_lo);

  sgm_top #(
    .BREAK_LO(BREAK_LO), .BREAK_REC(BREAK_REC), .CELL(CELL), .ONE_LO(ONE_LO),
    .ZERO_LO(ZERO_LO), .SAMPLE(SAMPLE), .RX_WAIT(RX_WAIT), .RST_CYCLES(RST_CYCLES),
    .REV_MAJOR(4'h1), .REV_MINOR(4'h3)
  ) i_sgm_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .line_i(line_i), .line_drive_lo_o(line_drive_lo_o), .irq_o(irq_o)
  );

  // low-pulse monitor on the line output
  always @(negedge clk_i) begin
    cyc++;
    if (line_drive_lo_o && !mon_prev && mon_n < 16) mon_st[mon_n] = cyc;
    if (!line_drive_lo_o && mon_prev && mon_n < 16) begin
      mon_w[mon_n] = cyc - mon_st[mon_n];
      mon_n++;
    end
    mon_prev = line_drive_lo_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #5 d = bus_rdata_o;
    @(negedge clk_i);
    bus_sel_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    int n = 0;
    do begin
      bus_read(5'h0C, v);
      n++;
    end while (v[4] && n < 3000);
    check(req, int'(v[4]), 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_read(5'h00, v); check("R1 R2 revision", v, 8'h13);
    bus_read(5'h0C, v); check("R1 control", v, 8'h00);
    bus_read(5'h10, v); check("R1 int status", v, 8'h00);
    bus_read(5'h18, v); check("R1 sys status", v, 8'h01);
    check("R1 line released", line_drive_lo_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_break;
    logic [7:0] v;
    mon_n = 0;
    bus_write(5'h0C, 8'h54);
    wait_idle("R3 go clears");
    check("R3 one pulse", mon_n, 1);
    check("R3 pulse width", mon_w[0], BREAK_LO);
    bus_read(5'h0C, v); check("R3 init and go cleared", v, 8'h40);
    check("R8 irq with ie and flag", irq_o, 1);
    bus_read(5'h10, v); check("R3 timeout flag", v, 8'h01);
    bus_read(5'h10, v); check("R7 cleared on read", v, 8'h00);
    check("R8 irq drops after clear", irq_o, 0);
  endtask

  task automatic t_tx(input logic [7:0] b);
    logic [7:0] v, dec;
    int bad_w = 0, bad_c = 0;
    mon_n = 0;
    bus_write(5'h04, b);
    bus_write(5'h0C, 8'h10);
    bus_write(5'h0C, 8'h56);
    bus_read(5'h0C, v); check("R9 write ignored while busy", v, 8'h10);
    wait_idle("R4 go clears");
    check("R4 pulse count", mon_n, 8);
    dec = '0;
    for (int i = 0; i < 8; i++) begin
      dec[i] = (mon_w[i] == ONE_LO);
      if (mon_w[i] != (b[i] ? ONE_LO : ZERO_LO)) bad_w++;
      if (i > 0 && mon_st[i] - mon_st[i-1] != CELL) bad_c++;
    end
    check("R4 lsb-first byte", dec, b);
    check("R4 low widths", bad_w, 0);
    check("R4 cell spacing", bad_c, 0);
    check("R8 no irq with ie clear", irq_o, 0);
    bus_read(5'h10, v); check("R4 tx complete flag", v, 8'h04);
  endtask

  task automatic slave_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      repeat (3) @(negedge clk_i);
      slave_lo = 1'b1;
      repeat (b[i] ? 5 : 25) @(negedge clk_i);
      slave_lo = 1'b0;
      repeat (b[i] ? 32 : 12) @(negedge clk_i);
    end
  endtask

  task automatic t_rx(input logic [7:0] b);
    logic [7:0] v;
    mon_n = 0;
    bus_write(5'h0C, 8'h52);
    slave_byte(b);
    wait_idle("R5 go clears");
    check("R11 master silent on receive", mon_n, 0);
    bus_read(5'h08, v); check("R5 received byte", v, b);
    check("R8 irq on receive", irq_o, 1);
    bus_read(5'h10, v); check("R5 rx complete flag", v, 8'h02);
  endtask

  task automatic t_rx_timeout(input logic [7:0] old);
    logic [7:0] v;
    bus_write(5'h0C, 8'h12);
    repeat (RX_WAIT + 10) @(negedge clk_i);
    wait_idle("R6 go clears");
    bus_read(5'h10, v); check("R6 timeout flag only", v, 8'h01);
    bus_read(5'h08, v); check("R6 rx data kept", v, old);
  endtask

  task automatic t_soft_reset;
    logic [7:0] v;
    bus_write(5'h0C, 8'h60);
    bus_write(5'h04, 8'h77);
    bus_write(5'h14, 8'h01);
    bus_read(5'h14, v); check("R10 auto-idle writable", v, 8'h01);
    bus_write(5'h14, 8'h02);
    bus_read(5'h18, v); check("R10 reset done low", v, 8'h00);
    repeat (RST_CYCLES + 4) @(negedge clk_i);
    bus_read(5'h18, v); check("R10 reset done high", v, 8'h01);
    bus_read(5'h0C, v); check("R10 control default", v, 8'h00);
    bus_read(5'h04, v); check("R10 tx data default", v, 8'h00);
    bus_read(5'h14, v); check("R10 sys config default", v, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_break();
    t_tx(8'hA5);
    t_tx(8'h0E);
    t_rx(8'h3C);
    t_rx(8'hD1);
    t_rx_timeout(8'hD1);
    t_soft_reset();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule